// File: doc/BRIEF.md
# Mailbox Acceptance Filter

This block sits behind a CAN protocol engine. It receives the descriptor of each completed frame: the identifier, a format flag (standard or extended), a data/remote type flag and a one-cycle valid strobe. It compares that identifier with the identifier programmed into every receive mailbox and picks the single mailbox that should store the message. On the next clock edge it emits a store strobe with the mailbox index, or a one-cycle no-match pulse if nothing accepts the frame.

Mailbox 0 alone has a don't-care mask. A 1 in the mask frees that identifier bit, so one mailbox can take a whole family of identifiers. With every mask bit set, it takes any identifier of its format. All other mailboxes need an exact match. Each mailbox keeps a data-frame pending flag and a remote-frame pending flag. Per-mailbox masks for each kind, plus one global mask, gate these flags into a single interrupt request.

A simple write port programs the block: the mailbox identifiers with their enables, the mailbox-0 mask, the interrupt masks, and the write-1-to-clear flag operations.

Top module: `mbx_accept_filter`

## Requirements
- R1: After synchronous reset, store_vld, nomatch and irq are 0. Both pending vectors are 0, every mailbox is disabled, all per-mailbox interrupt masks are 1 and the global mask is 1.
- R2: A mailbox other than 0 accepts a frame only when it is enabled, its format bit equals rx_ext, and every compared identifier bit equals its programmed identifier.
- R3: Mailbox 0 treats each identifier bit whose mask bit is 1 as don't care. With id 0x2AA and mask 0x003 it accepts 0x2A8 through 0x2AB, and with an all-ones mask it accepts any identifier of its format.
- R4: For a standard frame (rx_ext=0) only rx_id[10:0] is compared and rx_id[28:11] is ignored. For an extended frame all 29 bits are compared. A mailbox whose format differs from the frame never matches.
- R5: When several mailboxes accept, the lowest index wins, and exactly one store strobe is issued per frame.
- R6: On the clock edge that samples rx_vld=1, exactly one of these happens: store_vld rises with store_idx and store_rtr, or nomatch rises. Each pulse lasts one cycle.
- R7: A disabled mailbox is never selected, even when its identifier matches.
- R8: A store sets data_pend[idx] when rx_rtr=0 and rmt_pend[idx] when rx_rtr=1, on the same edge as the store strobe. If a clear and a set hit the same flag in the same cycle, the set wins.
- R9: Writing 1 to a bit of a clear operation clears that pending flag. Bits written as 0 leave their flags unchanged.
- R10: irq is 1 exactly when the global mask is 0 and some data_pend bit with data mask bit 0, or some rmt_pend bit with remote mask bit 0, is set.
- R11: Write port encoding by wr_kind:
  - 0 writes mailbox wr_idx: wr_data[28:0] is the identifier, [29] the extended flag, [30] the receive enable.
  - 1 writes the mailbox-0 mask from wr_data[28:0].
  - 2 writes the data interrupt masks and 3 the remote interrupt masks, each from wr_data[NUM_MBX-1:0].
  - 4 writes the global mask from wr_data[0].
  - 5 clears data flags and 6 clears remote flags, each from wr_data[NUM_MBX-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_vld | input | 1 | One-cycle strobe for a completed frame |
| rx_id | input | 29 | Received identifier (standard frames use bits 10:0) |
| rx_ext | input | 1 | 1 = extended format |
| rx_rtr | input | 1 | 1 = remote frame, 0 = data frame |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 3 | Write operation selector (R11) |
| wr_idx | input | IDX_W | Mailbox index for identifier writes |
| wr_data | input | 31 | Write data |
| store_vld | output | 1 | One-cycle store strobe |
| store_idx | output | IDX_W | Mailbox selected for storage |
| store_rtr | output | 1 | Type of the stored frame |
| nomatch | output | 1 | One-cycle pulse for a discarded frame |
| data_pend | output | NUM_MBX | Data-frame pending flags |
| rmt_pend | output | NUM_MBX | Remote-frame pending flags |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that rx_vld holds 0 during reset and that no frame arrives while an identifier write for the same cycle is being taken. Without that, the enable seen by the comparison could not be traced to a committed configuration. The stimulus changes inputs only on the falling edge. It issues each frame as an isolated one-cycle strobe, and it places every configuration write in its own cycles before the frames that depend on it, so each sampled outcome stems from one frame and a settled configuration.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int ID_W  = 29;
   localparam int STD_W = 11;
   localparam int WD_W  = ID_W + 2;

   typedef enum logic [2:0] {
      WK_ID    = 3'd0,
      WK_MASK  = 3'd1,
      WK_DMASK = 3'd2,
      WK_RMASK = 3'd3,
      WK_GMASK = 3'd4,
      WK_DCLR  = 3'd5,
      WK_RCLR  = 3'd6
   } wr_kind_e;

   typedef struct packed {
      logic            en;
      logic            ext;
      logic [ID_W-1:0] id;
   } mbx_cfg_t;
endpackage

// File: rtl/mbx_match_cell.sv
module mbx_match_cell
   import mbx_pkg::*;
(
   input  mbx_cfg_t        cfg,
   input  logic [ID_W-1:0] care_n,
   input  logic [ID_W-1:0] rx_id,
   input  logic            rx_ext,
   output logic            hit
);
   localparam logic [ID_W-1:0] STD_SPAN = {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};

   logic [ID_W-1:0] span;
   logic [ID_W-1:0] diff;

   always_comb begin
      span = rx_ext ? '1 : STD_SPAN;
      diff = (cfg.id ^ rx_id) & ~care_n & span;
      hit  = cfg.en && (cfg.ext == rx_ext) && (diff == '0);
   end
endmodule

// File: rtl/mbx_prio_pick.sv
module mbx_prio_pick #(
   parameter int NUM_MBX = 16,
   localparam int IDX_W = $clog2(NUM_MBX)
)(
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_MBX-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      idx = '0;
      for (int i = NUM_MBX - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
      any = |req;
   end

   // R5: the chosen request is live and nothing below it requests
   a_r5_lowest_wins: assert property (@(posedge clk) disable iff (rst)
      any |-> (req[idx] && ((req & ((NUM_MBX'(1) << idx) - NUM_MBX'(1))) == '0)));
endmodule

// File: rtl/mbx_flag_bank.sv
module mbx_flag_bank #(
   parameter int NUM_MBX = 16,
   localparam int IDX_W = $clog2(NUM_MBX)
)(
   input  logic               clk,
   input  logic               rst,
   input  logic               set_vld,
   input  logic               set_rtr,
   input  logic [IDX_W-1:0]   set_idx,
   input  logic [NUM_MBX-1:0] clr_d,
   input  logic [NUM_MBX-1:0] clr_r,
   input  logic [NUM_MBX-1:0] dmask,
   input  logic [NUM_MBX-1:0] rmask,
   input  logic               gmask,
   output logic [NUM_MBX-1:0] data_pend,
   output logic [NUM_MBX-1:0] rmt_pend,
   output logic               irq
);
   logic [NUM_MBX-1:0] one_hot;
   logic [NUM_MBX-1:0] set_d;
   logic [NUM_MBX-1:0] set_r;

   always_comb begin
      one_hot = set_vld ? (NUM_MBX'(1) << set_idx) : '0;
      set_d   = set_rtr ? '0 : one_hot;
      set_r   = set_rtr ? one_hot : '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         data_pend <= '0;
         rmt_pend  <= '0;
      end else begin
         data_pend <= (data_pend & ~clr_d) | set_d;
         rmt_pend  <= (rmt_pend  & ~clr_r) | set_r;
      end
   end

   assign irq = !gmask && (|((data_pend & ~dmask) | (rmt_pend & ~rmask)));

   // R8: a data store leaves its data flag set on the next cycle
   a_r8_data_set: assert property (@(posedge clk) disable iff (rst)
      (set_vld && !set_rtr) |=> data_pend[$past(set_idx)]);
   // R8: a remote store leaves its remote flag set on the next cycle
   a_r8_rmt_set: assert property (@(posedge clk) disable iff (rst)
      (set_vld && set_rtr) |=> rmt_pend[$past(set_idx)]);
   // R9: a cleared flag with no set in that cycle is gone next cycle
   a_r9_clear_d: assert property (@(posedge clk) disable iff (rst)
      (clr_d[0] && !(set_vld && !set_rtr && set_idx == '0)) |=> !data_pend[0]);
endmodule

// File: rtl/mbx_accept_filter.sv
module mbx_accept_filter
   import mbx_pkg::*;
#(
   parameter int NUM_MBX = 16,
   localparam int IDX_W = $clog2(NUM_MBX)
)(
   input  logic               clk,
   input  logic               rst,
   input  logic               rx_vld,
   input  logic [28:0]        rx_id,
   input  logic               rx_ext,
   input  logic               rx_rtr,
   input  logic               wr_en,
   input  logic [2:0]         wr_kind,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [30:0]        wr_data,
   output logic               store_vld,
   output logic [IDX_W-1:0]   store_idx,
   output logic               store_rtr,
   output logic               nomatch,
   output logic [NUM_MBX-1:0] data_pend,
   output logic [NUM_MBX-1:0] rmt_pend,
   output logic               irq
);
   generate
      if (NUM_MBX < 2 || NUM_MBX > 32) begin : g_bad_num
         $error("NUM_MBX must lie in 2..32");
      end
      if (WD_W != 31 || ID_W != 29) begin : g_bad_width
         $error("identifier width must be 29");
      end
   endgenerate

   wr_kind_e           kind;
   mbx_cfg_t           cfg [NUM_MBX];
   logic [ID_W-1:0]    mask0;
   logic [NUM_MBX-1:0] dmask, rmask;
   logic               gmask;
   logic [NUM_MBX-1:0] hits;
   logic [NUM_MBX-1:0] en_vec;
   logic [NUM_MBX-1:0] clr_d, clr_r;
   logic               pick_any;
   logic [IDX_W-1:0]   pick_idx;
   logic               take;

   assign kind = wr_kind_e'(wr_kind);

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NUM_MBX; i++) cfg[i] <= '0;
         mask0 <= '0;
         dmask <= '1;
         rmask <= '1;
         gmask <= 1'b1;
      end else if (wr_en) begin
         case (kind)
            WK_ID:    cfg[wr_idx] <= mbx_cfg_t'(wr_data);
            WK_MASK:  mask0 <= wr_data[ID_W-1:0];
            WK_DMASK: dmask <= wr_data[NUM_MBX-1:0];
            WK_RMASK: rmask <= wr_data[NUM_MBX-1:0];
            WK_GMASK: gmask <= wr_data[0];
            default: ;
         endcase
      end
   end

   always_comb begin
      clr_d = (wr_en && kind == WK_DCLR) ? wr_data[NUM_MBX-1:0] : '0;
      clr_r = (wr_en && kind == WK_RCLR) ? wr_data[NUM_MBX-1:0] : '0;
   end

   genvar k;
   generate
      for (k = 0; k < NUM_MBX; k++) begin : g_cell
         logic [ID_W-1:0] care_n;
         if (k == 0) begin : g_masked
            assign care_n = mask0;
         end else begin : g_exact
            assign care_n = '0;
         end
         assign en_vec[k] = cfg[k].en;
         mbx_match_cell u_cell (
            .cfg    (cfg[k]),
            .care_n (care_n),
            .rx_id  (rx_id),
            .rx_ext (rx_ext),
            .hit    (hits[k])
         );
      end
   endgenerate

   mbx_prio_pick #(.NUM_MBX(NUM_MBX)) u_pick (
      .clk (clk),
      .rst (rst),
      .req (hits),
      .any (pick_any),
      .idx (pick_idx)
   );

   assign take = rx_vld && pick_any;

   always_ff @(posedge clk) begin
      if (rst) begin
         store_vld <= 1'b0;
         nomatch   <= 1'b0;
         store_idx <= '0;
         store_rtr <= 1'b0;
      end else begin
         store_vld <= take;
         nomatch   <= rx_vld && !pick_any;
         if (take) begin
            store_idx <= pick_idx;
            store_rtr <= rx_rtr;
         end
      end
   end

   mbx_flag_bank #(.NUM_MBX(NUM_MBX)) u_flags (
      .clk       (clk),
      .rst       (rst),
      .set_vld   (take),
      .set_rtr   (rx_rtr),
      .set_idx   (pick_idx),
      .clr_d     (clr_d),
      .clr_r     (clr_r),
      .dmask     (dmask),
      .rmask     (rmask),
      .gmask     (gmask),
      .data_pend (data_pend),
      .rmt_pend  (rmt_pend),
      .irq       (irq)
   );

   // R6: a frame yields either a store or a discard, never both
   a_r6_single_outcome: assert property (@(posedge clk) disable iff (rst)
      !(store_vld && nomatch));
   // R6: either pulse follows a sampled frame strobe
   a_r6_needs_frame: assert property (@(posedge clk) disable iff (rst)
      (store_vld || nomatch) |-> $past(rx_vld));
   // R7: the stored mailbox was enabled when the frame was compared
   a_r7_enabled_only: assert property (@(posedge clk) disable iff (rst)
      store_vld |-> (($past(en_vec) & (NUM_MBX'(1) << store_idx)) != '0));
endmodule

// File: tb/sim_mbx_accept_filter.sv
module sim_mbx_accept_filter;
   localparam int CLK_PERIOD = 10;
   localparam int N = 16;

   typedef struct packed {
      logic        ext;
      logic        rtr;
      logic [28:0] id;
      logic        hit;
      logic [3:0]  idx;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b0, 29'h2A8,      1'b1, 4'd0},   // R3 masked low bits
      '{1'b0, 1'b0, 29'h2AB,      1'b1, 4'd0},   // R3
      '{1'b0, 1'b0, 29'h2AA,      1'b1, 4'd0},   // R5 mbx0 beats mbx1
      '{1'b0, 1'b0, 29'h2AE,      1'b0, 4'd0},   // R3 cared bit differs
      '{1'b0, 1'b1, 29'h155,      1'b1, 4'd2},   // R5 mbx2 beats mbx4, remote
      '{1'b1, 1'b0, 29'h1ABCDEF5, 1'b1, 4'd3},   // R4 extended exact
      '{1'b1, 1'b0, 29'h1ABCDEF4, 1'b0, 4'd0},   // R2 one bit off
      '{1'b0, 1'b0, 29'h100,      1'b0, 4'd0},   // R7 disabled mailbox
      '{1'b1, 1'b0, 29'h0F5,      1'b0, 4'd0},   // R4 format mismatch
      '{1'b0, 1'b0, 29'h0F5,      1'b1, 4'd6},   // R2 exact standard
      '{1'b0, 1'b0, 29'h1FFFF955, 1'b1, 4'd2}    // R4 upper bits ignored
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        rx_vld, rx_ext, rx_rtr;
   logic [28:0] rx_id;
   logic        wr_en;
   logic [2:0]  wr_kind;
   logic [3:0]  wr_idx;
   logic [30:0] wr_data;
   logic        store_vld, store_rtr, nomatch, irq;
   logic [3:0]  store_idx;
   logic [N-1:0] data_pend, rmt_pend;

   int n_run = 0;
   int n_fail = 0;
   logic [N-1:0] exp_d = '0;
   logic [N-1:0] exp_r = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_accept_filter #(.NUM_MBX(N)) u0 (
      .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_id(rx_id), .rx_ext(rx_ext),
      .rx_rtr(rx_rtr), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
      .wr_data(wr_data), .store_vld(store_vld), .store_idx(store_idx),
      .store_rtr(store_rtr), .nomatch(nomatch), .data_pend(data_pend),
      .rmt_pend(rmt_pend), .irq(irq)
   );

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] kind, input logic [3:0] idx,
                     input logic [30:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_kind = kind; wr_idx = idx; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cfg_id(input logic [3:0] idx, input logic en, input logic ext,
                         input logic [28:0] id);
      wr(3'd0, idx, {en, ext, id});
   endtask

   task automatic frame(input logic ext, input logic rtr, input logic [28:0] id,
                        input logic hit, input logic [3:0] idx, input string req);
      @(negedge clk);
      rx_vld = 1'b1; rx_ext = ext; rx_rtr = rtr; rx_id = id;
      @(negedge clk);
      rx_vld = 1'b0;
      chk(store_vld == hit && nomatch == !hit, req, {store_vld, nomatch}, {hit, !hit});
      if (hit) begin
         chk(store_idx == idx && store_rtr == rtr, req, {store_idx, store_rtr}, {idx, rtr});
         if (rtr) exp_r[idx] = 1'b1;
         else     exp_d[idx] = 1'b1;
      end
      chk(data_pend == exp_d && rmt_pend == exp_r, "R8 pending", {data_pend, rmt_pend},
          {exp_d, exp_r});
      @(negedge clk);
      chk(!store_vld && !nomatch, "R6 one-cycle pulse", {store_vld, nomatch}, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst = 1'b1; rx_vld = 1'b0; rx_ext = 1'b0; rx_rtr = 1'b0; rx_id = '0;
      wr_en = 1'b0; wr_kind = '0; wr_idx = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(!store_vld && !nomatch && !irq, "R1 outputs", {store_vld, nomatch, irq}, 0);
      chk(data_pend == '0 && rmt_pend == '0, "R1 pending", {data_pend, rmt_pend}, 0);
      frame(1'b0, 1'b0, 29'h0, 1'b0, 4'd0, "R1 all disabled");
      wr(3'd4, 4'd0, 31'd0);
      chk(!irq, "R1 interrupt masks set", irq, 0);

      // R11 programming
      cfg_id(4'd0, 1'b1, 1'b0, 29'h2AA);
      wr(3'd1, 4'd0, 31'h003);
      cfg_id(4'd1, 1'b1, 1'b0, 29'h2AA);
      cfg_id(4'd2, 1'b1, 1'b0, 29'h155);
      cfg_id(4'd3, 1'b1, 1'b1, 29'h1ABCDEF5);
      cfg_id(4'd4, 1'b1, 1'b0, 29'h155);
      cfg_id(4'd5, 1'b0, 1'b0, 29'h100);
      cfg_id(4'd6, 1'b1, 1'b0, 29'h0F5);

      for (int v = 0; v < NV; v++)
         frame(VEC[v].ext, VEC[v].rtr, VEC[v].id, VEC[v].hit, VEC[v].idx, "R2 R3 R4 R5 table");

      // R7 disabling mailbox 2 hands 0x155 to mailbox 4
      cfg_id(4'd2, 1'b0, 1'b0, 29'h155);
      frame(1'b0, 1'b0, 29'h155, 1'b1, 4'd4, "R7 disabled skipped");

      // R3 all-ones mask
      wr(3'd1, 4'd0, {2'b00, {29{1'b1}}});
      frame(1'b0, 1'b0, 29'h0F5, 1'b1, 4'd0, "R3 any id");
      frame(1'b0, 1'b0, 29'h7FF, 1'b1, 4'd0, "R3 any id");
      frame(1'b1, 1'b0, 29'h3,   1'b0, 4'd0, "R4 format still checked");

      // R10 interrupt gating
      chk(!irq, "R10 all masked", irq, 0);
      wr(3'd2, 4'd0, 31'h0000FFFE);
      chk(irq, "R10 data unmasked", irq, 1);
      wr(3'd4, 4'd0, 31'd1);
      chk(!irq, "R10 global mask", irq, 0);
      wr(3'd4, 4'd0, 31'd0);
      chk(irq, "R10 global cleared", irq, 1);

      // R9 write-one-to-clear
      wr(3'd5, 4'd0, 31'h1);
      exp_d[0] = 1'b0;
      chk(data_pend == exp_d, "R9 data clear", data_pend, exp_d);
      chk(!irq, "R10 cleared flag", irq, 0);
      wr(3'd3, 4'd0, 31'h0000FFFB);
      chk(irq, "R10 remote unmasked", irq, 1);
      wr(3'd6, 4'd0, 31'h0);
      chk(rmt_pend == exp_r, "R9 zero bits keep", rmt_pend, exp_r);
      wr(3'd6, 4'd0, 31'h4);
      exp_r[2] = 1'b0;
      chk(rmt_pend == exp_r && !irq, "R9 remote clear", {rmt_pend, irq}, {exp_r, 1'b0});

      // R8 set wins over a same-cycle clear
      @(negedge clk);
      rx_vld = 1'b1; rx_ext = 1'b0; rx_rtr = 1'b0; rx_id = 29'h0F5;
      wr_en = 1'b1; wr_kind = 3'd5; wr_data = 31'h1;
      @(negedge clk);
      rx_vld = 1'b0; wr_en = 1'b0;
      exp_d[0] = 1'b1;
      chk(data_pend == exp_d, "R8 set beats clear", data_pend, exp_d);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule